// File: doc/BRIEF.md
# Accumulator Fetch-Execute Sequencer

This block is the control core of a small accumulator machine. It steps each instruction through explicit register transfers. The program counter goes to the memory address register and then to memory. The returned word lands in the memory buffer register and moves from there to the current instruction register. Code and data share one memory. The block drives a one-way address bus and separate read and write strobes to that memory, and it holds each access until the memory answers with a one-cycle ready pulse.

Each instruction is a 16-bit word. Bits 15:12 hold the opcode and bits 11:0 hold an address field. The opcodes are 0 halt, 1 load, 2 store, 3 add, 4 subtract and 5 jump. Opcodes 6 to 15 do nothing.

An external interrupt request is latched into a pending flag. The flag is looked at only in a final step after the instruction has finished. When it is set, the program counter is saved in a shadow register and control goes to a fixed vector. A halt instruction parks the machine until a synchronous reset.

Top module: `acc_seq_core`

## Requirements
- R1: A synchronous active-low reset clears the program counter, the accumulator, the saved counter and the pending flag, drops both strobes and `halted`, and the first access after reset is a read at address 0.
- R2: Every instruction fetch reads at the current program counter. `mem_rd` and `mem_addr` stay unchanged until `mem_rdy` is seen.
- R3: The whole 16-bit word is taken as the instruction, with the opcode in bits 15:12 and the address in bits 11:0. Unless the instruction is a jump, the next fetch is at the previous fetch address plus one.
- R4: Load (opcode 1) reads the word at the address field and puts it in the accumulator.
- R5: Add (opcode 3) and subtract (opcode 4) read the word at the address field and combine it with the accumulator, modulo 2^16.
- R6: Store (opcode 2) writes the accumulator to the address field. `mem_wr` and the address stay held until `mem_rdy`, and `mem_rd` and `mem_wr` are never high together.
- R7: Jump (opcode 5) makes no operand access, and the next fetch is at the address field.
- R8: Halt (opcode 0) raises `halted`. From then until reset the block makes no memory access and ignores `irq`.
- R9: A high `irq` sets a pending flag. The flag is acted on only after the current instruction has finished. The block then copies the program counter (the next instruction to run) to `epc_out`, clears the flag and fetches next from address 0x010.
- R10: A request that is high in the same cycle the pending flag is taken stays pending. It is taken again after the first instruction of the service routine.
- R11: Opcodes 6 to 15 make no memory access and leave the accumulator unchanged. Only the program counter advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq | input | 1 | Interrupt request, sampled every cycle |
| mem_rdata | input | 16 | Read data from memory, valid with `mem_rdy` |
| mem_rdy | input | 1 | One-cycle completion pulse for the current access |
| mem_addr | output | 12 | Address of the current access |
| mem_rd | output | 1 | Read strobe, held until ready |
| mem_wr | output | 1 | Write strobe, held until ready |
| mem_wdata | output | 16 | Write data for a store |
| halted | output | 1 | High while the machine is parked by halt |
| acc_out | output | 16 | Accumulator contents |
| epc_out | output | 12 | Program counter saved at the last interrupt |

## Verification
Two things can happen in the same cycle: the end-of-instruction step takes the pending interrupt, and a new request arrives. The bench provokes this by holding `irq` high through the take. It releases `irq` only when it sees the read at the vector address. A correct block then interrupts the first vector instruction as well, so `epc_out` must read 0x011 and the vector word must be fetched exactly twice. A block that let the clear win would show 0x000 and a single vector fetch.

// File: rtl/acc_seq_pkg.sv
// Package: shared types for the accumulator sequencer.
// Holds the sequencer states, the opcode values, the ALU selections
// and the bundle of register-load strobes the controller sends to the datapath.
package acc_seq_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OPC_HALT  = 4'd0;
    localparam logic [OP_W-1:0] OPC_LOAD  = 4'd1;
    localparam logic [OP_W-1:0] OPC_STORE = 4'd2;
    localparam logic [OP_W-1:0] OPC_ADD   = 4'd3;
    localparam logic [OP_W-1:0] OPC_SUB   = 4'd4;
    localparam logic [OP_W-1:0] OPC_JUMP  = 4'd5;

    typedef enum logic [3:0] {
        ST_FADDR,
        ST_FREAD,
        ST_FLOAD,
        ST_DECODE,
        ST_OPREAD,
        ST_EXEC,
        ST_OPWRITE,
        ST_CHKIRQ,
        ST_HALT
    } seq_state_e;

    typedef enum logic [1:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB
    } alu_op_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_fld;
        logic mbr_from_mem;
        logic mbr_from_acc;
        logic cir_load;
        logic pc_inc;
        logic pc_from_fld;
        logic acc_load;
        logic irq_take;
    } seq_ctrl_t;

endpackage

// File: rtl/acc_seq_alu.sv
// Module: acc_seq_alu
// Combinational accumulator ALU. It passes the operand through, adds it
// or subtracts it, and the result wraps modulo 2^DATA_W.
// Assumes the select is steady while the accumulator loads.
module acc_seq_alu
    import acc_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           sel,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] res
);

    // Pick the arithmetic result for the selected operation.
    always_comb begin
        case (sel)
            ALU_ADD: res = acc + opnd;
            ALU_SUB: res = acc - opnd;
            default: res = opnd;
        endcase
    end

endmodule

// File: rtl/acc_seq_ctrl.sv
// Module: acc_seq_ctrl
// Multi-cycle state machine for the fetch, decode, operand and execute
// steps. It sends one-cycle load strobes to the datapath registers and
// holds the memory strobes until ready. The interrupt is looked at only in
// the end-of-instruction state. Assumes the opcode input comes from the
// instruction register and is valid from the decode state on.
module acc_seq_ctrl
    import acc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    input  logic            mem_rdy,
    input  logic            irq_pend,
    output seq_ctrl_t       ctl,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            halted
);

    seq_state_e state, state_nx;

    // State register with synchronous reset to the start of a fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FADDR;
        else        state <= state_nx;
    end

    // Next state and register-transfer strobes for the current step.
    always_comb begin
        state_nx = state;
        ctl      = '0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        case (state)
            ST_FADDR: begin
                ctl.mar_from_pc = 1'b1;
                state_nx        = ST_FREAD;
            end
            ST_FREAD: begin
                mem_rd = 1'b1;
                if (mem_rdy) begin
                    ctl.mbr_from_mem = 1'b1;
                    state_nx         = ST_FLOAD;
                end
            end
            ST_FLOAD: begin
                ctl.cir_load = 1'b1;
                ctl.pc_inc   = 1'b1;
                state_nx     = ST_DECODE;
            end
            ST_DECODE: begin
                ctl.mar_from_fld = 1'b1;
                case (opcode)
                    OPC_HALT:                   state_nx = ST_HALT;
                    OPC_LOAD, OPC_ADD, OPC_SUB: state_nx = ST_OPREAD;
                    OPC_STORE: begin
                        ctl.mbr_from_acc = 1'b1;
                        state_nx         = ST_OPWRITE;
                    end
                    OPC_JUMP: begin
                        ctl.pc_from_fld = 1'b1;
                        state_nx        = ST_CHKIRQ;
                    end
                    default:                    state_nx = ST_CHKIRQ;
                endcase
            end
            ST_OPREAD: begin
                mem_rd = 1'b1;
                if (mem_rdy) begin
                    ctl.mbr_from_mem = 1'b1;
                    state_nx         = ST_EXEC;
                end
            end
            ST_EXEC: begin
                ctl.acc_load = 1'b1;
                state_nx     = ST_CHKIRQ;
            end
            ST_OPWRITE: begin
                mem_wr = 1'b1;
                if (mem_rdy) state_nx = ST_CHKIRQ;
            end
            ST_CHKIRQ: begin
                ctl.irq_take = irq_pend;
                state_nx     = ST_FADDR;
            end
            ST_HALT:  state_nx = ST_HALT;
            default:  state_nx = ST_FADDR;
        endcase
    end

    assign halted = (state == ST_HALT);

    AST_HALT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (halted && !mem_rd && !mem_wr)); // R8

    AST_EXEC_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC) |-> ($past(mem_rd) && $past(mem_rdy))); // R4

endmodule

// File: rtl/acc_seq_core.sv
// Module: acc_seq_core
// Top of the accumulator sequencer. It holds the named registers (program
// counter, memory address, memory buffer, current instruction, accumulator,
// saved counter) and the interrupt pending flag, and wires them to the
// controller and the ALU. Assumes one memory that answers each held strobe
// with a single-cycle ready pulse, with read data valid in that cycle.
module acc_seq_core
    import acc_seq_pkg::*;
#(
    parameter int                 ADDR_W = 12,
    parameter int                 DATA_W = 16,
    parameter logic [ADDR_W-1:0]  VECTOR = 'h010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rdy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              halted,
    output logic [DATA_W-1:0] acc_out,
    output logic [ADDR_W-1:0] epc_out
);

    localparam int               OP_LSB = DATA_W - OP_W;
    localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] pc_q, mar_q, epc_q;
    logic [DATA_W-1:0] mbr_q, cir_q, acc_q, alu_res;
    logic              pend_q;
    logic [OP_W-1:0]   opcode;
    logic [ADDR_W-1:0] field;
    alu_op_e           alu_sel;
    seq_ctrl_t         ctl;

    assign opcode = cir_q[DATA_W-1:OP_LSB];
    assign field  = cir_q[ADDR_W-1:0];

    acc_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (opcode),
        .mem_rdy  (mem_rdy),
        .irq_pend (pend_q),
        .ctl      (ctl),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .halted   (halted)
    );

    // Map the held opcode to an ALU operation.
    always_comb begin
        case (opcode)
            OPC_ADD: alu_sel = ALU_ADD;
            OPC_SUB: alu_sel = ALU_SUB;
            default: alu_sel = ALU_PASS;
        endcase
    end

    acc_seq_alu #(.DATA_W(DATA_W)) u_alu (
        .sel  (alu_sel),
        .acc  (acc_q),
        .opnd (mbr_q),
        .res  (alu_res)
    );

    // Program counter: go to the vector, the jump target, or advance by one.
    always_ff @(posedge clk) begin
        if (!rst_n)               pc_q <= '0;
        else if (ctl.irq_take)    pc_q <= VECTOR;
        else if (ctl.pc_from_fld) pc_q <= field;
        else if (ctl.pc_inc)      pc_q <= pc_q + PC_ONE;
    end

    // Memory address register: loaded from the counter or the address field.
    always_ff @(posedge clk) begin
        if (!rst_n)                mar_q <= '0;
        else if (ctl.mar_from_pc)  mar_q <= pc_q;
        else if (ctl.mar_from_fld) mar_q <= field;
    end

    // Memory buffer register: takes read data, or the accumulator for a store.
    always_ff @(posedge clk) begin
        if (!rst_n)                mbr_q <= '0;
        else if (ctl.mbr_from_mem) mbr_q <= mem_rdata;
        else if (ctl.mbr_from_acc) mbr_q <= acc_q;
    end

    // Instruction and accumulator registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cir_q <= '0;
            acc_q <= '0;
        end else begin
            if (ctl.cir_load) cir_q <= mbr_q;
            if (ctl.acc_load) acc_q <= alu_res;
        end
    end

    // Interrupt bookkeeping: a new request beats the clear; save the counter on a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            epc_q  <= '0;
        end else begin
            pend_q <= (pend_q && !ctl.irq_take) || irq;
            if (ctl.irq_take) epc_q <= pc_q;
        end
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mbr_q;
    assign acc_out   = acc_q;
    assign epc_out   = epc_q;

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R6

    AST_RD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_rdy) |=> (mem_rd && $stable(mem_addr))); // R2

    AST_WR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_rdy) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata))); // R6

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_inc |=> (pc_q == $past(pc_q) + PC_ONE)); // R3

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_from_fld |=> (pc_q == $past(field))); // R7

    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.irq_take |=> (pc_q == VECTOR && epc_q == $past(pc_q))); // R9

    AST_IRQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.irq_take && irq) |=> pend_q); // R10

endmodule

// File: tb/acc_seq_core_tb.sv
// Bench for acc_seq_core: a memory responder with random ready delays,
// an instruction-level reference model, and directed and random programs.
module acc_seq_core_tb;

    localparam int AW = 12;
    localparam int DW = 16;
    localparam int MEMN = 4096;
    localparam int TRN = 1024;
    localparam logic [AW-1:0] VEC = 12'h010;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq = 1'b0;
    logic [DW-1:0] mem_rdata;
    logic          mem_rdy;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [DW-1:0] mem_wdata;
    logic          halted;
    logic [DW-1:0] acc_out;
    logic [AW-1:0] epc_out;

    always #5 clk = ~clk;

    acc_seq_core #(.ADDR_W(AW), .DATA_W(DW), .VECTOR(VEC)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .halted(halted), .acc_out(acc_out), .epc_out(epc_out)
    );

    logic [DW-1:0] mem [0:MEMN-1];
    logic [DW-1:0] mdl_mem [0:MEMN-1];
    logic          tr_we [0:TRN-1];
    logic [AW-1:0] tr_addr [0:TRN-1];
    logic [DW-1:0] tr_data [0:TRN-1];
    int            tr_n;
    logic          ex_we [0:TRN-1];
    logic [AW-1:0] ex_addr [0:TRN-1];
    logic [DW-1:0] ex_data [0:TRN-1];
    string         ex_tag [0:TRN-1];
    int            ex_n;
    logic [DW-1:0] ex_acc;
    int            checks = 0;
    int            errors = 0;

    function automatic logic [DW-1:0] ins(input int op, input int fld);
        return {op[3:0], fld[11:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Memory responder: random wait, one-cycle ready, records every access.
    initial begin
        int wcnt;
        wcnt = 0;
        mem_rdy = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_rdy = 1'b0;
            if (!rst_n) wcnt = 0;
            else if (mem_rd || mem_wr) begin
                if (wcnt > 0) wcnt--;
                else begin
                    mem_rdy = 1'b1;
                    if (tr_n < TRN) begin
                        tr_we[tr_n]   = mem_wr;
                        tr_addr[tr_n] = mem_addr;
                        tr_data[tr_n] = mem_wr ? mem_wdata : mem[mem_addr];
                    end
                    tr_n++;
                    if (mem_wr) mem[mem_addr] = mem_wdata;
                    else        mem_rdata = mem[mem_addr];
                    wcnt = $urandom_range(0, 3);
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic clear_mem();
        for (int i = 0; i < MEMN; i++) mem[i] = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        irq = 1'b0;
        repeat (3) @(negedge clk);
        tr_n = 0;
        chk(!halted && !mem_rd && !mem_wr && acc_out == 0 && epc_out == 0, "R1",
            "reset state", {halted, mem_rd, mem_wr, acc_out, epc_out}, 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_halt(input int maxc);
        for (int i = 0; i < maxc && !halted; i++) @(negedge clk);
        chk(halted, "R8", "halted raised", halted, 1);
    endtask

    task automatic push(input logic we, input int a, input logic [DW-1:0] d, input string t);
        if (ex_n < TRN) begin
            ex_we[ex_n] = we; ex_addr[ex_n] = a[AW-1:0]; ex_data[ex_n] = d; ex_tag[ex_n] = t;
        end
        ex_n++;
    endtask

    // Instruction-level model built from the requirements.
    task automatic run_model();
        int pc, f, steps;
        logic [DW-1:0] ir, acc;
        bit done;
        string ftag;
        for (int i = 0; i < MEMN; i++) mdl_mem[i] = mem[i];
        pc = 0; acc = '0; ex_n = 0; done = 0; steps = 0; ftag = "R1";
        while (!done && steps < 400) begin
            steps++;
            ir = mdl_mem[pc];
            push(1'b0, pc, ir, ftag);
            ftag = "R3";
            pc = (pc + 1) % MEMN;
            f = int'(ir[11:0]);
            case (ir[15:12])
                4'd0: done = 1;
                4'd1: begin push(1'b0, f, mdl_mem[f], "R4"); acc = mdl_mem[f]; end
                4'd2: begin push(1'b1, f, acc, "R6"); mdl_mem[f] = acc; end
                4'd3: begin push(1'b0, f, mdl_mem[f], "R5"); acc = acc + mdl_mem[f]; end
                4'd4: begin push(1'b0, f, mdl_mem[f], "R5"); acc = acc - mdl_mem[f]; end
                4'd5: begin pc = f; ftag = "R7"; end
                default: ftag = "R11";
            endcase
        end
        ex_acc = acc;
    endtask

    task automatic compare_run();
        chk(tr_n == ex_n, "R3", "access count", tr_n, ex_n);
        for (int i = 0; i < ex_n && i < tr_n && i < TRN; i++)
            chk(tr_we[i] == ex_we[i] && tr_addr[i] == ex_addr[i] && tr_data[i] == ex_data[i],
                ex_tag[i], $sformatf("access %0d we/addr/data", i),
                {tr_we[i], tr_addr[i], tr_data[i]}, {ex_we[i], ex_addr[i], ex_data[i]});
        chk(acc_out == ex_acc, "R5", "final accumulator", acc_out, ex_acc);
    endtask

    function automatic int vec_fetches();
        int n = 0;
        for (int i = 0; i < tr_n && i < TRN; i++)
            if (!tr_we[i] && tr_addr[i] == VEC) n++;
        return n;
    endfunction

    initial begin
        int bad, n, r, j;
        void'($urandom(32'h5eed_0011));
        tr_n = 0;

        // Directed: arithmetic with wrap, store, halt.
        clear_mem();
        mem[0] = ins(1, 'h100); mem[1] = ins(3, 'h101); mem[2] = ins(4, 'h102);
        mem[3] = ins(2, 'h103); mem[4] = ins(0, 0);
        mem['h100] = 16'h7FFF; mem['h101] = 16'h0002; mem['h102] = 16'h8002;
        run_model();
        do_reset();
        wait_halt(2000);
        compare_run();
        chk(tr_addr[0] == 0, "R1", "first fetch address", tr_addr[0], 0);
        chk(acc_out == 16'hFFFF, "R5", "wrap result", acc_out, 16'hFFFF);
        chk(mem['h103] == 16'hFFFF, "R6", "stored word", mem['h103], 16'hFFFF);

        // Halt parking: no access and irq ignored.
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            irq = $urandom_range(0, 1);
            @(negedge clk);
            if (!halted || mem_rd || mem_wr) bad++;
        end
        irq = 1'b0;
        chk(bad == 0, "R8", "parked cycles with activity", bad, 0);
        chk(epc_out == 0, "R8", "irq ignored while halted", epc_out, 0);

        // Directed: jumps skip code.
        clear_mem();
        mem[0] = ins(5, 3); mem[1] = ins(1, 'h100); mem[2] = ins(0, 0);
        mem[3] = ins(1, 'h101); mem[4] = ins(5, 2);
        mem['h100] = 16'hDEAD; mem['h101] = 16'h0042;
        run_model();
        do_reset();
        wait_halt(2000);
        compare_run();
        chk(acc_out == 16'h0042, "R7", "skipped load has no effect", acc_out, 16'h0042);

        // Interrupt taken only after the running instruction finishes.
        clear_mem();
        mem[0] = ins(1, 'h100); mem[1] = ins(2, 'h102); mem[2] = ins(5, 2);
        mem[VEC] = ins(2, 'h103); mem[VEC+1] = ins(0, 0);
        mem['h100] = 16'h5A5A; mem['h102] = 16'h1111;
        do_reset();
        @(negedge clk); @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        wait_halt(2000);
        chk(epc_out == 1, "R9", "saved counter", epc_out, 1);
        chk(mem['h103] == 16'h5A5A, "R9", "interrupted load completed", mem['h103], 16'h5A5A);
        chk(mem['h102] == 16'h1111, "R9", "next instruction not run", mem['h102], 16'h1111);
        chk(vec_fetches() == 1, "R9", "vector fetches", vec_fetches(), 1);

        // Request held through the take: re-pends and interrupts the handler.
        clear_mem();
        mem[0] = ins(5, 0);
        mem[VEC] = ins(1, 'h100); mem[VEC+1] = ins(0, 0);
        mem['h100] = 16'h0777;
        do_reset();
        repeat (10) @(negedge clk);
        irq = 1'b1;
        for (int i = 0; i < 500 && !(mem_rd && mem_addr == VEC); i++) @(negedge clk);
        irq = 1'b0;
        wait_halt(2000);
        chk(epc_out == VEC + 1, "R10", "saved counter after second take", epc_out, VEC + 1);
        chk(vec_fetches() == 2, "R10", "vector fetches", vec_fetches(), 2);
        chk(acc_out == 16'h0777, "R10", "handler result", acc_out, 16'h0777);

        // Random programs checked against the model.
        for (int it = 0; it < 25; it++) begin
            clear_mem();
            n = $urandom_range(4, 40);
            for (int k = 0; k < n; k++) begin
                r = $urandom_range(0, 9);
                j = 'h100 + $urandom_range(0, 15);
                if (r < 2)       mem[k] = ins(1, j);
                else if (r < 4)  mem[k] = ins(3, j);
                else if (r < 6)  mem[k] = ins(4, j);
                else if (r < 8)  mem[k] = ins(2, j);
                else if (r == 8) mem[k] = ins($urandom_range(6, 15), $urandom_range(0, 4095));
                else begin
                    j = k + $urandom_range(1, 2);
                    if (j > n) j = n;
                    mem[k] = ins(5, j);
                end
            end
            mem[n] = ins(0, 0);
            for (int d = 'h100; d < 'h110; d++) mem[d] = 16'($urandom);
            run_model();
            do_reset();
            wait_halt(5000);
            compare_run();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule